// File: doc/BRIEF.md
# Converter Power-Up Reset Sequencer

This block generates the active-low reset for an analog-to-digital converter macro. After chip reset the macro is held in reset. Two conditions must both be true before the reset is released: the converter enable input and a software run bit. Once both are sampled high, the block keeps the reset low for a base of 6 clock cycles plus a programmable 6-bit extension. It then releases the reset and raises a ready status flag on the same clock edge.

The extension value has two stages. Software first writes a pending value. That value only takes effect after a load strobe. The load status bit reads 1 for exactly one cycle and then clears itself. The committed value is captured into the down-counter when the hold starts, so a commit made during a hold does not change the delay already running. Dropping either gating condition returns the sequencer to its off state, and the next start counts the full delay again.

Two state machines make up the block. The release machine has the states OFF, HOLD and ON, with these transitions:
- OFF→HOLD: the gate condition is sampled high.
- HOLD→ON: the counter has reached zero.
- HOLD→OFF and ON→OFF: the gate condition is low.

The load machine has the states LD_IDLE and LD_COMMIT, with these transitions:
- LD_IDLE→LD_COMMIT: a load write arrives.
- LD_COMMIT→LD_IDLE: always, on the next edge, which also copies the pending value into the committed value.

Top module: `rstseq_top`

## Requirements
- R1: After chip reset `macro_rst_n`, `pwr_ready` and `load_busy` are 0, and the committed extension is 0.
- R2: With a committed extension of 0, `macro_rst_n` rises on the 6th rising edge after the first edge that samples `conv_en` and `sw_run` both high.
- R3: With a committed extension N (0..63), the release happens N+6 edges after that first edge; N=63 gives 69.
- R4: While `sw_run` is 0, `macro_rst_n` stays 0 whatever `conv_en` does.
- R5: When either `conv_en` or `sw_run` is sampled low, `macro_rst_n` and `pwr_ready` are 0 after that edge. A later start counts the full N+6 again.
- R6: `pwr_ready` equals `macro_rst_n` in every cycle.
- R7: A `load_wr` pulse sets `load_busy` at the edge that samples it. `load_busy` clears at the following edge, and that same edge copies the pending extension into the committed value.
- R8: Writing the pending extension (`ext_wr`, `ext_wdata`) without a load leaves the release delay unchanged.
- R9: The delay uses the committed value present before the starting edge. A commit on the starting edge, or during HOLD, does not alter the running delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Chip reset, active low, asynchronous |
| conv_en | input | 1 | Converter enable |
| sw_run | input | 1 | Software reset-control bit, 1 allows release |
| ext_wr | input | 1 | Write strobe for pending extension |
| ext_wdata | input | 6 | Pending extension value |
| load_wr | input | 1 | Load strobe, commits pending extension |
| load_busy | output | 1 | Load bit readback, self-clearing |
| macro_rst_n | output | 1 | Reset to converter macro, active low |
| pwr_ready | output | 1 | Reset-released status flag |

## Verification
The two functions that can land in one cycle are a load commit and the start of a hold. The bench provokes this by pulsing `load_wr` one cycle before raising the enable. The commit edge and the starting edge are then the same edge. The bench judges the result by the measured release delay, which must match the previously committed extension and not the new one. A second commit issued mid-HOLD is judged the same way. The new value is then confirmed on the following run.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
    localparam int EXT_W  = 6;
    localparam int BASE   = 6;
    localparam int CNT_W  = $clog2((1 << EXT_W) + BASE);

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HOLD = 2'd1,
        ST_ON   = 2'd2
    } rel_state_t;

    typedef enum logic {
        LD_IDLE   = 1'b0,
        LD_COMMIT = 1'b1
    } ld_state_t;
endpackage

// File: rtl/rstseq_cfg.sv
module rstseq_cfg
    import rstseq_pkg::*;
#(
    parameter int W = EXT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ext_wr,
    input  logic [W-1:0] ext_wdata,
    input  logic         load_wr,
    output logic         load_busy,
    output logic [W-1:0] ext_commit
);
    ld_state_t    state, nstate;
    logic [W-1:0] pending;

    always_comb begin
        nstate = state;
        unique case (state)
            LD_IDLE:   if (load_wr) nstate = LD_COMMIT;
            LD_COMMIT: nstate = LD_IDLE;
            default:   nstate = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LD_IDLE;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending    <= '0;
            ext_commit <= '0;
            load_busy  <= 1'b0;
        end else begin
            if (ext_wr) pending <= ext_wdata;
            if (state == LD_COMMIT) ext_commit <= pending;
            load_busy <= (nstate == LD_COMMIT);
        end
    end

    // R7: load bit clears itself one cycle after being set
    a_r7_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        load_busy |=> !load_busy);
    // R7: a load write while idle sets the bit
    a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
        (load_wr && !load_busy) |=> load_busy);
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
    import rstseq_pkg::*;
#(
    parameter int W  = EXT_W,
    parameter int B  = BASE,
    parameter int CW = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] ext_val,
    output logic         rel_n,
    output logic         ready
);
    localparam logic [CW-1:0] LOAD_OFS = CW'(B - 1);

    rel_state_t    state, nstate;
    logic [CW-1:0] cnt;

    always_comb begin
        nstate = state;
        unique case (state)
            ST_OFF:  if (go) nstate = ST_HOLD;
            ST_HOLD: begin
                if (!go)           nstate = ST_OFF;
                else if (cnt == 0) nstate = ST_ON;
            end
            ST_ON:   if (!go) nstate = ST_OFF;
            default: nstate = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (state == ST_OFF && go) begin
            cnt <= CW'(ext_val) + LOAD_OFS;
        end else if (state == ST_HOLD && cnt != 0) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rel_n <= 1'b0;
            ready <= 1'b0;
        end else begin
            rel_n <= (nstate == ST_ON);
            ready <= (nstate == ST_ON);
        end
    end

    // R5: losing the gate forces reset low after the edge
    a_r5_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> !rel_n);
    // R9: the running count only steps down while holding
    a_r9_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && go && cnt != 0) |=> (cnt == $past(cnt) - 1'b1));
    // R2: release only follows a gate that was high
    a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rel_n) |-> $past(go));
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int W = EXT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         conv_en,
    input  logic         sw_run,
    input  logic         ext_wr,
    input  logic [W-1:0] ext_wdata,
    input  logic         load_wr,
    output logic         load_busy,
    output logic         macro_rst_n,
    output logic         pwr_ready
);
    logic [W-1:0] ext_commit;
    logic         go;

    assign go = conv_en & sw_run;

    rstseq_cfg #(.W(W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_wr    (ext_wr),
        .ext_wdata (ext_wdata),
        .load_wr   (load_wr),
        .load_busy (load_busy),
        .ext_commit(ext_commit)
    );

    rstseq_ctrl #(.W(W), .B(BASE), .CW(CNT_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (go),
        .ext_val(ext_commit),
        .rel_n  (macro_rst_n),
        .ready  (pwr_ready)
    );

    // R6: status flag tracks reset release every cycle
    a_r6_match: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_ready == macro_rst_n);
    // R4: software bit low keeps the macro in reset
    a_r4_sw_low: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_run |=> !macro_rst_n);
endmodule

// File: tb/rstseq_top_tb.sv
module rstseq_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_en = 1'b0, sw_run = 1'b0, ext_wr = 1'b0, load_wr = 1'b0;
    logic [5:0] ext_wdata = '0;
    logic       load_busy, macro_rst_n, pwr_ready;

    int checks = 0, failures = 0;
    int exp_q[$];
    int edge_cnt = 0;
    logic prev_rel = 1'b0;

    always #4 clk = ~clk;

    rstseq_top u_dut (
        .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .sw_run(sw_run),
        .ext_wr(ext_wr), .ext_wdata(ext_wdata), .load_wr(load_wr),
        .load_busy(load_busy), .macro_rst_n(macro_rst_n), .pwr_ready(pwr_ready)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // edges since gate first sampled high
    always @(posedge clk) begin
        if (rst_n && conv_en && sw_run) edge_cnt <= edge_cnt + 1;
        else                            edge_cnt <= 0;
    end

    // monitor: pops expected delay on each release
    always @(negedge clk) begin
        if (rst_n) begin
            if (pwr_ready != macro_rst_n) chk("R6 ready vs reset", pwr_ready, macro_rst_n);
            if (!prev_rel && macro_rst_n) begin
                if (exp_q.size() == 0) chk("R2/R3 unexpected release", 1, 0);
                else chk("R3 release delay", edge_cnt - 1, exp_q.pop_front());
            end
        end
        prev_rel <= macro_rst_n;
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_ext(logic [5:0] v);
        ext_wr = 1'b1; ext_wdata = v;
        cyc(1);
        ext_wr = 1'b0;
    endtask

    task automatic do_load();
        load_wr = 1'b1;
        cyc(1);
        load_wr = 1'b0;
    endtask

    task automatic wait_release(int limit);
        for (int i = 0; i < limit; i++) begin
            cyc(1);
            if (macro_rst_n) break;
        end
        cyc(1);
    endtask

    task automatic run(int exp_delay);
        exp_q.push_back(exp_delay);
        conv_en = 1'b1; sw_run = 1'b1;
        wait_release(100);
        chk("R2/R3 queue drained", exp_q.size(), 0);
    endtask

    task automatic stop();
        conv_en = 1'b0;
        cyc(1);
        chk("R5 reset low after enable drop", macro_rst_n, 0);
        chk("R5 ready low after enable drop", pwr_ready, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cyc(2);
        chk("R1 reset low", macro_rst_n, 0);
        chk("R1 ready low", pwr_ready, 0);
        chk("R1 load bit low", load_busy, 0);
        rst_n = 1'b1;
        cyc(2);

        // R1/R2: committed extension starts at 0
        run(6);
        stop();

        // R8: pending write without load
        write_ext(6'd10);
        run(6);
        stop();

        // R7: load strobe, self-clearing bit
        load_wr = 1'b1;
        cyc(1);
        load_wr = 1'b0;
        chk("R7 load bit set", load_busy, 1);
        cyc(1);
        chk("R7 load bit cleared", load_busy, 0);
        run(16);
        stop();

        // R3: maximum extension
        write_ext(6'd63);
        do_load();
        cyc(1);
        run(69);
        stop();

        // R4: software bit low holds reset
        conv_en = 1'b1; sw_run = 1'b0;
        cyc(80);
        chk("R4 reset held with sw bit low", macro_rst_n, 0);
        run(69);
        sw_run = 1'b0;
        cyc(1);
        chk("R5 reset low after sw bit drop", macro_rst_n, 0);
        conv_en = 1'b0;
        cyc(1);

        // R5: interrupt a hold, restart counts full delay
        conv_en = 1'b1; sw_run = 1'b1;
        cyc(20);
        conv_en = 1'b0;
        cyc(1);
        chk("R5 still in reset after abort", macro_rst_n, 0);
        run(69);
        stop();

        // R9: commit on the starting edge uses the old value
        write_ext(6'd3);
        load_wr = 1'b1;
        cyc(1);
        load_wr = 1'b0;
        exp_q.push_back(69);
        conv_en = 1'b1; sw_run = 1'b1;
        // R9: another commit in the middle of the hold
        cyc(5);
        write_ext(6'd5);
        do_load();
        wait_release(100);
        chk("R9 queue drained", exp_q.size(), 0);
        stop();
        run(11);
        stop();

        cyc(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule